// File: doc/BRIEF.md
# Clock-Stretch-Acknowledged Serial Master

This block drives a two-wire-plus-clock serial link that has no select line. It behaves like SPI mode 3: the clock idles high, data changes when the clock falls, and data is sampled when the clock rises. For each transfer it shifts one byte out on `mosi` while it shifts one byte in from `miso`. The clock wire is shared and open-drain. The master only ever pulls it low (`sck_pull_lo`) and watches the resolved level on `sck_in`.

When the eighth bit has gone out, the master stops driving the clock and parks `mosi` high. It then waits for the slave to hold the clock wire low as an acknowledge/busy pulse. Once the slave lets the clock go, the master reports the received byte with a one-cycle `done`. It then holds off further transfers for a minimum quiet gap.

A `fast_mode` input, sampled at each start, chooses between slow timing (6.5 µs half period) and fast timing (1 µs half period). Every interval is counted in system clocks derived from the `CLK_HZ` parameter. A separate request plays the power-on wake pattern on `mosi`.

Top module: `ackstretch_ser_master`

## Requirements
- R1: Out of reset, `ready`=1, `sck_pull_lo`=0, `mosi`=1, `done`=0 and `ack_err`=0.
- R2: After a start is accepted, the clock stays released and `mosi` keeps its previous level for a lead-in of 18 µs (slow) or 4 µs (fast). Only then does the first falling edge come.
- R3: Each byte is 8 bits, sent most significant bit first. `mosi` takes a new bit in the same cycle that `sck_pull_lo` rises, and it does not change while the clock is pulled low.
- R4: Each low half and each non-final high half of the clock lasts 6.5 µs in slow mode and 1 µs in fast mode.
- R5: `miso` is sampled at each clock release, most significant bit first. The assembled byte appears on `rx_byte` together with a `done` pulse exactly one cycle wide.
- R6: 1 µs after the last release of the clock, `mosi` goes high. The clock is then left released.
- R7: The master waits for the synchronized clock line to go low and then return high. `done` is asserted on the third clock edge after the line returns high, because a two-flop synchronizer sits in the path.
- R8: After the acknowledge ends, `ready` stays low for 120 µs (slow) or 18 µs (fast), counted from the `done` cycle.
- R9: If the line does not go low within `ACK_TO_US` µs after `mosi` is parked, `ack_err` is set and the block returns to ready without `done`. `ack_err` stays set until reset.
- R10: A wake request drives `mosi` low for 1 µs, high for 42 µs, low for 6.5 µs and high for 103 µs, then returns to ready. The clock is never pulled during the wake pattern.
- R11: `start` and `wake_req` are ignored while `ready`=0. `fast_mode` and `tx_byte` are captured only when a start is accepted.
- R12: If `wake_req` and `start` arrive in the same ready cycle, the wake pattern runs and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a byte transfer when ready |
| wake_req | input | 1 | Begin the power-on wake pattern when ready |
| fast_mode | input | 1 | 1 selects fast timing, 0 slow; captured at start |
| tx_byte | input | BITS | Byte to send |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle strobe: byte finished and rx_byte valid |
| rx_byte | output | BITS | Last byte received from the slave |
| ack_err | output | 1 | Sticky acknowledge-timeout flag |
| sck_pull_lo | output | 1 | Pull the shared clock line low |
| sck_in | input | 1 | Sensed level of the shared clock line |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
A wrong state or a wrong timer load changes the cycle in which `sck_pull_lo`, `mosi` or `ready` toggles. The bench's timeline model compares all of these on every clock, so such a fault shows up within one cycle of the first misplaced edge. A wrong bit index or capture order only shows up at the `done` cycle, as a wrong `rx_byte`, or as a misplaced `mosi` level one half period into the byte. A broken acknowledge handshake shows up either as a `done` that is early or missing relative to the slave's release, or as `ack_err` rising when the slave did answer.

// File: rtl/asm_pkg.sv
package asm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_ACKW,
    ST_ACKH,
    ST_GAP,
    ST_WK1,
    ST_WK2,
    ST_WK3,
    ST_WK4
  } asm_state_e;

  // cycles for a duration given in tenths of a microsecond
  function automatic int unsigned cyc_of(input int unsigned per_us, input int unsigned tenths);
    return (per_us * tenths) / 10;
  endfunction

endpackage

// File: rtl/asm_sync2.sv
module asm_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/asm_timer.sv
module asm_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asm_rx_shift.sv
module asm_rx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (en) sh_d = {sh_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q;
endmodule

// File: rtl/ackstretch_ser_master.sv
module ackstretch_ser_master
  import asm_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned ACK_TO_US = 200,
  parameter int unsigned BITS      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wake_req,
  input  logic            fast_mode,
  input  logic [BITS-1:0] tx_byte,
  output logic            ready,
  output logic            done,
  output logic [BITS-1:0] rx_byte,
  output logic            ack_err,
  output logic            sck_pull_lo,
  input  logic            sck_in,
  output logic            mosi,
  input  logic            miso
);

  localparam int unsigned PER_US  = CLK_HZ / 1_000_000;
  localparam int unsigned N_HALF_S = cyc_of(PER_US, 65);
  localparam int unsigned N_HALF_F = cyc_of(PER_US, 10);
  localparam int unsigned N_LEAD_S = cyc_of(PER_US, 180);
  localparam int unsigned N_LEAD_F = cyc_of(PER_US, 40);
  localparam int unsigned N_TAIL   = cyc_of(PER_US, 10);
  localparam int unsigned N_GAP_S  = cyc_of(PER_US, 1200);
  localparam int unsigned N_GAP_F  = cyc_of(PER_US, 180);
  localparam int unsigned N_ACK_TO = PER_US * ACK_TO_US;
  localparam int unsigned N_WK1    = cyc_of(PER_US, 10);
  localparam int unsigned N_WK2    = cyc_of(PER_US, 420);
  localparam int unsigned N_WK3    = cyc_of(PER_US, 65);
  localparam int unsigned N_WK4    = cyc_of(PER_US, 1030);
  localparam int unsigned MAX_CYC  = N_GAP_S + N_WK4 + N_ACK_TO + 2;
  localparam int unsigned TW       = $clog2(MAX_CYC);
  localparam int unsigned BW       = (BITS > 1) ? $clog2(BITS) : 1;

  localparam logic [TW-1:0] LD_HALF_S = TW'(N_HALF_S - 1);
  localparam logic [TW-1:0] LD_HALF_F = TW'(N_HALF_F - 1);
  localparam logic [TW-1:0] LD_LEAD_S = TW'(N_LEAD_S - 1);
  localparam logic [TW-1:0] LD_LEAD_F = TW'(N_LEAD_F - 1);
  localparam logic [TW-1:0] LD_TAIL   = TW'(N_TAIL - 1);
  localparam logic [TW-1:0] LD_GAP_S  = TW'(N_GAP_S - 1);
  localparam logic [TW-1:0] LD_GAP_F  = TW'(N_GAP_F - 1);
  localparam logic [TW-1:0] LD_ACK_TO = TW'(N_ACK_TO - 1);
  localparam logic [TW-1:0] LD_WK1    = TW'(N_WK1 - 1);
  localparam logic [TW-1:0] LD_WK2    = TW'(N_WK2 - 1);
  localparam logic [TW-1:0] LD_WK3    = TW'(N_WK3 - 1);
  localparam logic [TW-1:0] LD_WK4    = TW'(N_WK4 - 1);

  asm_state_e    st_q, st_d;
  logic          pull_q, pull_d;
  logic          mosi_q, mosi_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          fast_q, fast_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [BITS-1:0] tx_q;
  logic [BITS-1:0] rx_q;
  logic [BITS-1:0] shift_w;
  logic          tx_ld, rx_sh, rx_cap;
  logic          tm_ld, tm_zero;
  logic [TW-1:0] tm_val;
  logic          sck_s;

  asm_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_in), .q(sck_s)
  );

  asm_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_ld), .load_val(tm_val), .zero(tm_zero)
  );

  asm_rx_shift #(.W(BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_sh), .din(miso), .q(shift_w)
  );

  always_comb begin
    st_d   = st_q;
    pull_d = pull_q;
    mosi_d = mosi_q;
    done_d = 1'b0;
    err_d  = err_q;
    fast_d = fast_q;
    bit_d  = bit_q;
    tx_ld  = 1'b0;
    rx_sh  = 1'b0;
    rx_cap = 1'b0;
    tm_ld  = 1'b0;
    tm_val = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (wake_req) begin
          st_d = ST_WK1; mosi_d = 1'b0; tm_ld = 1'b1; tm_val = LD_WK1;
        end else if (start) begin
          st_d = ST_LEAD; fast_d = fast_mode; tx_ld = 1'b1; tm_ld = 1'b1;
          tm_val = fast_mode ? LD_LEAD_F : LD_LEAD_S;
        end
      end
      ST_LEAD: if (tm_zero) begin
        st_d = ST_LOW; pull_d = 1'b1; mosi_d = tx_q[BITS-1];
        bit_d = BW'(BITS - 1); tm_ld = 1'b1;
        tm_val = fast_q ? LD_HALF_F : LD_HALF_S;
      end
      ST_LOW: if (tm_zero) begin
        pull_d = 1'b0; rx_sh = 1'b1; tm_ld = 1'b1;
        if (bit_q == '0) begin
          st_d = ST_TAIL; tm_val = LD_TAIL;
        end else begin
          st_d = ST_HIGH; tm_val = fast_q ? LD_HALF_F : LD_HALF_S;
        end
      end
      ST_HIGH: if (tm_zero) begin
        st_d = ST_LOW; pull_d = 1'b1; bit_d = bit_q - BW'(1);
        mosi_d = tx_q[bit_q - BW'(1)]; tm_ld = 1'b1;
        tm_val = fast_q ? LD_HALF_F : LD_HALF_S;
      end
      ST_TAIL: if (tm_zero) begin
        st_d = ST_ACKW; mosi_d = 1'b1; tm_ld = 1'b1; tm_val = LD_ACK_TO;
      end
      ST_ACKW: begin
        if (!sck_s)       st_d = ST_ACKH;
        else if (tm_zero) begin st_d = ST_IDLE; err_d = 1'b1; end
      end
      ST_ACKH: if (sck_s) begin
        st_d = ST_GAP; done_d = 1'b1; rx_cap = 1'b1; tm_ld = 1'b1;
        tm_val = fast_q ? LD_GAP_F : LD_GAP_S;
      end
      ST_GAP: if (tm_zero) st_d = ST_IDLE;
      ST_WK1: if (tm_zero) begin
        st_d = ST_WK2; mosi_d = 1'b1; tm_ld = 1'b1; tm_val = LD_WK2;
      end
      ST_WK2: if (tm_zero) begin
        st_d = ST_WK3; mosi_d = 1'b0; tm_ld = 1'b1; tm_val = LD_WK3;
      end
      ST_WK3: if (tm_zero) begin
        st_d = ST_WK4; mosi_d = 1'b1; tm_ld = 1'b1; tm_val = LD_WK4;
      end
      ST_WK4: if (tm_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
      mosi_q <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      fast_q <= 1'b0;
      bit_q  <= '0;
    end else begin
      st_q   <= st_d;
      pull_q <= pull_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
      err_q  <= err_d;
      fast_q <= fast_d;
      bit_q  <= bit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_ld) tx_q <= tx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_q <= '0;
    else if (rx_cap) rx_q <= shift_w;
  end

  assign ready       = (st_q == ST_IDLE);
  assign done        = done_q;
  assign rx_byte     = rx_q;
  assign ack_err     = err_q;
  assign sck_pull_lo = pull_q;
  assign mosi        = mosi_q;

endmodule

// File: rtl/asm_checker.sv
module asm_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic wake_req,
  input logic ready,
  input logic done,
  input logic ack_err,
  input logic sck_pull_lo,
  input logic mosi
);

  // R3: data holds while the clock is held low
  a_r3_mosi_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_pull_lo && $past(sck_pull_lo)) |-> $stable(mosi));

  // R5: completion strobe is one cycle wide
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: completion only with the clock released
  a_r7_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sck_pull_lo);

  // R9: error flag holds once set
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |=> ack_err);

  // R11: leaving idle needs a request
  a_r11_leave_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(start || wake_req));

  // R10: the clock is only pulled while busy
  a_r10_pull_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sck_pull_lo |-> !ready);

endmodule

bind ackstretch_ser_master asm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .wake_req(wake_req),
  .ready(ready), .done(done), .ack_err(ack_err),
  .sck_pull_lo(sck_pull_lo), .mosi(mosi)
);

// File: tb/ackstretch_ser_master_tb_top.sv
`timescale 1ns/1ps
module ackstretch_ser_master_tb_top;

  // 8 cycles per microsecond keeps every interval short
  localparam int unsigned CPU   = 8;
  localparam int unsigned TO_US = 40;
  localparam int H_S = 52, H_F = 8, LEAD_S = 144, LEAD_F = 32, TAIL = 8;
  localparam int GAP_S = 960, GAP_F = 144, N_TO = CPU * TO_US;
  localparam int WK1 = 8, WK2 = 336, WK3 = 52, WK4 = 824;

  logic clk = 1'b0;
  logic rst_n, start, wake_req, fast_mode, miso, slave_pull;
  logic [7:0] tx_byte;
  logic ready, done, ack_err, sck_pull_lo, mosi;
  logic [7:0] rx_byte;
  logic sck_line;

  int nvec = 0;
  int nfail = 0;
  logic exp_err = 1'b0;
  logic [7:0] exp_rx = 8'h00;

  always #4 clk = ~clk;

  assign sck_line = !(sck_pull_lo || slave_pull);

  ackstretch_ser_master #(
    .CLK_HZ(CPU * 1_000_000), .ACK_TO_US(TO_US), .BITS(8)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wake_req(wake_req),
    .fast_mode(fast_mode), .tx_byte(tx_byte), .ready(ready), .done(done),
    .rx_byte(rx_byte), .ack_err(ack_err), .sck_pull_lo(sck_pull_lo),
    .sck_in(sck_line), .mosi(mosi), .miso(miso)
  );

  task automatic step(input logic ep, input logic em, input logic er,
                      input logic ed, input logic ee, input string tag);
    @(negedge clk);
    nvec++;
    if ({sck_pull_lo, mosi, ready, done, ack_err} !== {ep, em, er, ed, ee}) begin
      nfail++;
      $display("FAIL %s: pull/mosi/ready/done/err got %b%b%b%b%b exp %b%b%b%b%b at %0t",
               tag, sck_pull_lo, mosi, ready, done, ack_err, ep, em, er, ed, ee, $time);
    end
    if (ed && rx_byte !== exp_rx) begin
      nfail++;
      $display("FAIL R5 rx_byte: got %h exp %h", rx_byte, exp_rx);
    end
  endtask

  task automatic run_byte(input logic [7:0] tx, input logic [7:0] rxv, input logic fst,
                          input bit ack, input int busy, input bit poke);
    int half = fst ? H_F : H_S;
    int lead = fst ? LEAD_F : LEAD_S;
    int gap  = fst ? GAP_F : GAP_S;
    fast_mode = fst; tx_byte = tx; start = 1'b1;
    for (int k = 0; k < lead; k++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0, exp_err, "R2 lead-in");
      if (k == 0) start = 1'b0;
      if (poke && k == 2) begin start = 1'b1; tx_byte = ~tx; fast_mode = ~fst; end
      if (poke && k == 3) start = 1'b0;
    end
    for (int i = 7; i >= 0; i--) begin
      for (int k = 0; k < half; k++) begin
        step(1'b1, tx[i], 1'b0, 1'b0, exp_err, "R3 R4 low half");
        if (k == 0) miso = rxv[i];
      end
      for (int k = 0; k < ((i == 0) ? TAIL : half); k++)
        step(1'b0, tx[i], 1'b0, 1'b0, exp_err, (i == 0) ? "R6 tail" : "R4 high half");
    end
    if (ack) begin
      for (int k = 0; k < 13 * CPU; k++)
        step(1'b0, 1'b1, 1'b0, 1'b0, exp_err, "R6 parked");
      slave_pull = 1'b1;
      for (int k = 0; k < busy; k++)
        step(1'b0, 1'b1, 1'b0, 1'b0, exp_err, "R7 busy");
      slave_pull = 1'b0;
      step(1'b0, 1'b1, 1'b0, 1'b0, exp_err, "R7 sync delay");
      step(1'b0, 1'b1, 1'b0, 1'b0, exp_err, "R7 sync delay");
      exp_rx = rxv;
      step(1'b0, 1'b1, 1'b0, 1'b1, exp_err, "R5 done");
      for (int k = 0; k < gap - 1; k++)
        step(1'b0, 1'b1, 1'b0, 1'b0, exp_err, "R8 gap");
      step(1'b0, 1'b1, 1'b1, 1'b0, exp_err, "R8 ready");
    end else begin
      for (int k = 0; k < N_TO; k++)
        step(1'b0, 1'b1, 1'b0, 1'b0, exp_err, "R9 waiting");
      exp_err = 1'b1;
      step(1'b0, 1'b1, 1'b1, 1'b0, exp_err, "R9 timeout");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wake_req = 1'b0; fast_mode = 1'b0;
    tx_byte = 8'h00; miso = 1'b0; slave_pull = 1'b0;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R1 reset");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R1 after release");

    // slow byte, short acknowledge
    run_byte(8'hA5, 8'h3C, 1'b0, 1'b1, 4 * CPU, 1'b0);
    // fast byte, long busy, stray start and mode change during lead-in (R11)
    run_byte(8'h81, 8'hC3, 1'b1, 1'b1, 200, 1'b1);
    // fast byte, alternate pattern
    run_byte(8'h5E, 8'hE7, 1'b1, 1'b1, 5 * CPU, 1'b0);

    // wake with simultaneous start: wake wins (R10, R12)
    wake_req = 1'b1; start = 1'b1; tx_byte = 8'hFF;
    for (int k = 0; k < WK1; k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, exp_err, "R10 R12 wake low 1");
      wake_req = 1'b0; start = 1'b0;
    end
    for (int k = 0; k < WK2; k++) step(1'b0, 1'b1, 1'b0, 1'b0, exp_err, "R10 wake high 1");
    for (int k = 0; k < WK3; k++) step(1'b0, 1'b0, 1'b0, 1'b0, exp_err, "R10 wake low 2");
    for (int k = 0; k < WK4; k++) step(1'b0, 1'b1, 1'b0, 1'b0, exp_err, "R10 wake high 2");
    step(1'b0, 1'b1, 1'b1, 1'b0, exp_err, "R10 R12 ready after wake");
    step(1'b0, 1'b1, 1'b1, 1'b0, exp_err, "R12 start dropped");

    // no acknowledge: timeout then sticky flag
    run_byte(8'h3C, 8'h00, 1'b0, 1'b0, 0, 1'b0);
    run_byte(8'h96, 8'h69, 1'b1, 1'b1, 6 * CPU, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, exp_err, "R9 flag held");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule